// File: doc/BRIEF.md
# Nibble-Serial Sample Word Link

This block sits on the converter side of a three-lane nibble-serial link that moves 16-bit sample words to and from a digital processor. It divides its fast input clock by four to make the nibble clock. It also makes an active-low word strobe. The two signals are shared by all three lanes.

On the receive lane, the block takes a parallel word and sends it out as four 4-bit nibbles, least significant nibble first. On the transmit and transmit-enable lanes, it gathers four incoming nibbles into a 16-bit word per lane. It presents both words together with a one-cycle valid pulse.

Outgoing nibbles change with the rising edge of the nibble clock, and incoming nibbles are captured at its falling edge. While reset is asserted, all digital state is cleared and the word strobe stays high. The nibble clock output passes the input clock straight through during reset, so the far side keeps a clock.

Top module: `nsw_link`

## Requirements
- R1: `frame_no` is low for exactly one nibble period (2^DIV_LOG2 input clock cycles) at the start of each word, aligned with nibble N0. It is high during nibbles N1 to N3.
- R2: Outside reset, `nib_clk_o` is the input clock divided by 2^DIV_LOG2. It is high in the first half of each nibble period and low in the second half. During reset, `nib_clk_o` follows `clk_i`.
- R3: The word on `rx_data_i` is loaded at the start of N0 and sent on `rxd_o` with bits [3:0] in N0, [7:4] in N1, [11:8] in N2 and [15:12] in N3. `rxd_o` changes only when the nibble clock rises.
- R4: If `rx_valid_i` is low in the cycle before N0 starts, the receive lane sends an all-zero word.
- R5: `txd_i` and `txe_i` are captured at the falling edge of the nibble clock. The first nibble captured in a word becomes bits [3:0] of the assembled word, and the last becomes bits [15:12].
- R6: `tx_valid_o` is high for exactly one input clock cycle, in the cycle after N3 is captured. `tx_data_o` and `txe_data_o` carry the two assembled words in that cycle.
- R7: While `rst_ni` is low, `frame_no` is high, and `rxd_o`, `tx_valid_o`, `tx_data_o` and `txe_data_o` are zero.
- R8: The first input clock edge after reset is released starts N0 of a new word. A word that was only partly received when reset was asserted never appears on the outputs.
- R9: `rx_ready_o` is high in the last input clock cycle of every word, and only then. A word offered with `rx_valid_i` in that cycle is the one sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 16 | Receive-path word to be serialized |
| rx_valid_i | input | 1 | `rx_data_i` holds a word |
| rx_ready_o | output | 1 | The word offered now is loaded at the next edge |
| tx_data_o | output | 16 | Assembled transmit-data word |
| txe_data_o | output | 16 | Assembled transmit-enable word |
| tx_valid_o | output | 1 | One-cycle pulse when the assembled words are valid |
| nib_clk_o | output | 1 | Shared nibble clock |
| frame_no | output | 1 | Shared word strobe, active low during N0 |
| rxd_o | output | 4 | Receive nibble lane |
| txd_i | input | 4 | Transmit-data nibble lane |
| txe_i | input | 4 | Transmit-enable nibble lane |

## Verification
The bench builds the block with a 16-bit word, 4-bit nibbles and a divide-by-four nibble clock, so every nibble period has exactly two high and two low input cycles. With these values the bench can check each phase of the nibble clock, the strobe and the valid pulse cycle by cycle against a processor model that uses the same framing. Back-to-back words, words with no valid input, and a reset in the middle of a word all fit in a short run, and random words exercise every nibble position on all three lanes.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
  // per-cycle timing events for the edge that follows
  typedef struct packed {
    logic load;    // N0 begins: load receive word
    logic launch;  // nibble clock rises: advance receive lane
    logic capt;    // nibble clock falls: capture incoming nibbles
    logic last;    // capture of N3
  } nsw_tick_t;
endpackage

// File: rtl/nsw_timing.sv
module nsw_timing
  import nsw_pkg::*;
#(
  parameter int DIV_LOG2 = 2,
  parameter int NIB_LOG2 = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  output nsw_tick_t tick_o,
  output logic      nclk_o,
  output logic      frame_no,
  output logic      ready_o,
  output logic      done_o
);
  localparam int CW = DIV_LOG2 + NIB_LOG2;
  localparam logic [DIV_LOG2-1:0] HALF = DIV_LOG2'(1) << (DIV_LOG2 - 1);

  logic [CW-1:0]       cnt_q, cnt_d;
  logic [DIV_LOG2-1:0] ph_d;
  logic [NIB_LOG2-1:0] nib_d;
  logic                nclk_q, frame_q, done_q;

  assign cnt_d = cnt_q + CW'(1);
  assign ph_d  = cnt_d[DIV_LOG2-1:0];
  assign nib_d = cnt_d[CW-1:DIV_LOG2];

  always_comb begin
    tick_o.load   = (cnt_d == '0);
    tick_o.launch = (ph_d == '0);
    tick_o.capt   = (ph_d == HALF);
    tick_o.last   = (ph_d == HALF) && (nib_d == '1);
  end

  // counter parks on the last slot in reset so the first edge opens N0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      nclk_q  <= 1'b0;
      frame_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      nclk_q  <= ~ph_d[DIV_LOG2-1];
      frame_q <= (nib_d != '0);
      done_q  <= tick_o.last;
    end
  end

  assign nclk_o   = nclk_q;
  assign frame_no = frame_q;
  assign ready_o  = (cnt_q == '1);
  assign done_o   = done_q;
endmodule

// File: rtl/nsw_ser.sv
module nsw_ser #(
  parameter int WORD_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              launch_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [NIB_W-1:0]  lane_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (load_i)   sh_q <= valid_i ? data_i : '0;
    else if (launch_i) sh_q <= sh_q >> NIB_W;
  end

  assign lane_o = sh_q[NIB_W-1:0];
endmodule

// File: rtl/nsw_deser.sv
module nsw_deser #(
  parameter int WORD_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capt_i,
  input  logic              last_i,
  input  logic [NIB_W-1:0]  lane_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] acc_q, word_q, acc_d;

  // newest nibble enters at the top, so N0 ends in the low bits
  assign acc_d = {lane_i, acc_q[WORD_W-1:NIB_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      word_q <= '0;
    end else begin
      if (capt_i) acc_q  <= acc_d;
      if (last_i) word_q <= acc_d;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/nsw_link.sv
module nsw_link
  import nsw_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NIB_W    = 4,
  parameter int DIV_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [WORD_W-1:0] tx_data_o,
  output logic [WORD_W-1:0] txe_data_o,
  output logic              tx_valid_o,
  output logic              nib_clk_o,
  output logic              frame_no,
  output logic [NIB_W-1:0]  rxd_o,
  input  logic [NIB_W-1:0]  txd_i,
  input  logic [NIB_W-1:0]  txe_i
);
  localparam int NIBBLES  = WORD_W / NIB_W;
  localparam int NIB_LOG2 = $clog2(NIBBLES);
  localparam int IN_LANES = 2;

  nsw_tick_t tick;
  logic      nclk;

  nsw_timing #(.DIV_LOG2(DIV_LOG2), .NIB_LOG2(NIB_LOG2)) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_o  (tick),
    .nclk_o  (nclk),
    .frame_no(frame_no),
    .ready_o (rx_ready_o),
    .done_o  (tx_valid_o)
  );

  // clock stays available to the far side while in reset
  assign nib_clk_o = rst_ni ? nclk : clk_i;

  nsw_ser #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tick.load),
    .launch_i(tick.launch),
    .valid_i (rx_valid_i),
    .data_i  (rx_data_i),
    .lane_o  (rxd_o)
  );

  logic [IN_LANES-1:0][NIB_W-1:0]  lane_in;
  logic [IN_LANES-1:0][WORD_W-1:0] lane_word;

  assign lane_in = {txe_i, txd_i};

  for (genvar g = 0; g < IN_LANES; g++) begin : g_in
    nsw_deser #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_deser (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .capt_i(tick.capt),
      .last_i(tick.last),
      .lane_i(lane_in[g]),
      .word_o(lane_word[g])
    );
  end

  assign tx_data_o  = lane_word[0];
  assign txe_data_o = lane_word[1];
endmodule

// File: rtl/nsw_link_chk.sv
module nsw_link_chk #(
  parameter int NIB_W    = 4,
  parameter int DIV_LOG2 = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_no,
  input logic             nib_clk_o,
  input logic [NIB_W-1:0] rxd_o,
  input logic             tx_valid_o,
  input logic             rx_ready_o
);
  localparam int DIV = 1 << DIV_LOG2;
  localparam int LW  = DIV_LOG2 + 2;

  logic [LW-1:0] low_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_len_q <= '0;
    else if (frame_no) low_len_q <= '0;
    else               low_len_q <= low_len_q + LW'(1);
  end

  assert_strobe_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_no) |-> (low_len_q == LW'(DIV)));

  assert_rx_on_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rxd_o) |-> $rose(nib_clk_o));

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);

  assert_valid_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (!nib_clk_o && frame_no));

  assert_ready_n0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |=> !frame_no);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_strobe_R7: assert (frame_no);
    end
  end
endmodule

bind nsw_link nsw_link_chk #(.NIB_W(NIB_W), .DIV_LOG2(DIV_LOG2)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frame_no  (frame_no),
  .nib_clk_o (nib_clk_o),
  .rxd_o     (rxd_o),
  .tx_valid_o(tx_valid_o),
  .rx_ready_o(rx_ready_o)
);

// File: tb/nsw_link_tb.sv
module nsw_link_tb;
  localparam int WW  = 16;
  localparam int NW  = 4;
  localparam int DL  = 2;
  localparam int DIV = 1 << DL;
  localparam int NN  = WW / NW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [WW-1:0] rx_data_i = '0;
  logic          rx_valid_i = 1'b0;
  logic          rx_ready_o;
  logic [WW-1:0] tx_data_o, txe_data_o;
  logic          tx_valid_o, nib_clk_o, frame_no;
  logic [NW-1:0] rxd_o;
  logic [NW-1:0] txd_i = '0, txe_i = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  nsw_link #(.WORD_W(WW), .NIB_W(NW), .DIV_LOG2(DL)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i),
    .rx_ready_o(rx_ready_o), .tx_data_o(tx_data_o), .txe_data_o(txe_data_o),
    .tx_valid_o(tx_valid_o), .nib_clk_o(nib_clk_o), .frame_no(frame_no),
    .rxd_o(rxd_o), .txd_i(txd_i), .txe_i(txe_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one full word in both directions, processor model on the far side
  task automatic xfer(input logic [WW-1:0] rxw, input bit use_v,
                      input logic [WW-1:0] txw, input logic [WW-1:0] tew);
    logic [WW-1:0] rexp = use_v ? rxw : '0;
    logic [WW-1:0] got = '0;
    while (!rx_ready_o) @(negedge clk_i);
    chk(rx_ready_o, "R9 ready before N0", 32'(rx_ready_o), 1);
    rx_valid_i = use_v;
    rx_data_i  = rxw;
    txd_i = txw[NW-1:0];
    txe_i = tew[NW-1:0];
    for (int k = 0; k < NN * DIV; k++) begin
      int nib = k / DIV;
      int ph  = k % DIV;
      @(negedge clk_i);
      if (k == 0) rx_valid_i = 1'b0;
      if (ph == 0) begin
        chk(frame_no == (nib != 0), "R1 strobe", 32'(frame_no), 32'(nib != 0));
        chk(nib_clk_o == 1'b1, "R2 nibble clock high", 32'(nib_clk_o), 1);
        chk(rxd_o == rexp[nib*NW +: NW], use_v ? "R3 rx nibble" : "R4 rx zero nibble",
            32'(rxd_o), 32'(rexp[nib*NW +: NW]));
        txd_i = txw[nib*NW +: NW];
        txe_i = tew[nib*NW +: NW];
      end
      if (ph == DIV / 2) begin
        chk(nib_clk_o == 1'b0, "R2 nibble clock low", 32'(nib_clk_o), 0);
        got[nib*NW +: NW] = rxd_o;
      end
      if (k == NN * DIV - 3) chk(tx_valid_o == 1'b0, "R6 no early valid", 32'(tx_valid_o), 0);
      if (k == NN * DIV - 2) begin
        chk(tx_valid_o == 1'b1, "R6 valid pulse", 32'(tx_valid_o), 1);
        chk(tx_data_o == txw, "R5 tx word", 32'(tx_data_o), 32'(txw));
        chk(txe_data_o == tew, "R5 txe word", 32'(txe_data_o), 32'(tew));
      end
      if (k == NN * DIV - 1) begin
        chk(tx_valid_o == 1'b0, "R6 valid one cycle", 32'(tx_valid_o), 0);
        chk(rx_ready_o == 1'b1, "R9 ready last cycle", 32'(rx_ready_o), 1);
      end
    end
    chk(got == rexp, "R3 rx round trip", 32'(got), 32'(rexp));
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    @(posedge clk_i); #1;
    chk(nib_clk_o == 1'b1, "R2 reset clock follows high", 32'(nib_clk_o), 1);
    @(negedge clk_i); #1;
    chk(nib_clk_o == 1'b0, "R2 reset clock follows low", 32'(nib_clk_o), 0);
    chk(frame_no == 1'b1, "R7 strobe high", 32'(frame_no), 1);
    chk(rxd_o == '0, "R7 rx lane idle", 32'(rxd_o), 0);
    chk(tx_valid_o == 1'b0, "R7 no valid", 32'(tx_valid_o), 0);
    chk(tx_data_o == '0 && txe_data_o == '0, "R7 words clear", 32'(tx_data_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_first_word();
    // R8: the first edge after release opens N0
    xfer(16'h1234, 1'b1, 16'h8421, 16'hF00F);
  endtask

  task automatic t_patterns();
    xfer(16'hFFFF, 1'b1, 16'h0000, 16'hFFFF);
    xfer(16'h0001, 1'b1, 16'h8000, 16'h0F0F);
    xfer(16'hA5C3, 1'b0, 16'h5A3C, 16'h1248); // R4
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++)
      xfer(WW'($urandom), 1'b1, WW'($urandom), WW'($urandom));
  endtask

  task automatic t_mid_reset();
    while (!rx_ready_o) @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_data_i  = 16'hDEAD;
    txd_i = 4'hA;
    txe_i = 4'h5;
    repeat (6) @(negedge clk_i);
    rx_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(frame_no == 1'b1, "R7 strobe high on reset", 32'(frame_no), 1);
    chk(rxd_o == '0, "R7 rx cleared", 32'(rxd_o), 0);
    repeat (3) @(negedge clk_i);
    chk(tx_valid_o == 1'b0 && tx_data_o == '0, "R8 partial word dropped", 32'(tx_data_o), 0);
    rst_ni = 1'b1;
    chk(rx_ready_o == 1'b1, "R8 N0 opens at first edge", 32'(rx_ready_o), 1);
    xfer(16'h0BEE, 1'b1, 16'h7654, 16'h3210);
  endtask

  initial begin
    t_reset_state();
    t_first_word();
    t_patterns();
    t_random();
    t_mid_reset();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end
endmodule